// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block recovers characters from an asynchronous serial line. The line is sampled on a clock enable that runs at sixteen times the bit rate. A low level is accepted as a start bit only when it is still low at the middle of that bit. The data bits are then sampled once each, at the centre of their bit periods, with the least significant bit first. An optional parity bit and one or two stop bits follow. The data-bit count, the parity rule and the stop-bit count come from static configuration inputs.

Each finished character leaves the block as a one-cycle strobe. The strobe carries the data and three status flags: parity error, framing error and line break. These are meant for a receive buffer downstream. A break is a line held low through every sample of a character, the stop bits included. It is reported as an all-zero character with only the break flag set.

A break can begin in the middle of a character. In that case the block first delivers the damaged character with its error flags. If the low level then lasts for another full character, an all-zero break character follows. After any break, the block waits until the line has stayed high for half a bit time before it looks for a new start bit.

Top module: `uart_brk_rx`

## Requirements
- R1: During and right after reset, `rx_valid` is 0 and `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are all 0.
- R2: Data bits arrive least significant bit first. The count is 5 + `cfg_data_bits` (0 to 3 gives 5 to 8 bits). Bits of `rx_data` above that count are 0.
- R3: Each character raises `rx_valid` for exactly one clock. The strobe comes near the middle of the last stop bit. Data and flags stay stable until the next strobe.
- R4: A low is accepted as a start bit only if it is still low at the eighth oversample tick after it was seen. A shorter low pulse produces no character.
- R5: `cfg_parity` encodes the parity rule: 0 none, 1 even, 2 odd, 3 parity bit must be 1. `rx_perr` is set only when a parity bit is present and does not match the rule. With code 0 no parity bit is expected.
- R6: A low level at the first stop-bit sample sets `rx_ferr`. The character is still delivered with its data.
- R7: With `cfg_two_stop` = 1, a second stop bit is sampled and the strobe moves one bit later. The second stop bit never causes a framing error.
- R8: A character whose every sample is low, stop bits included, is delivered as data 0 with `rx_brk` = 1 and `rx_perr` = `rx_ferr` = 0.
- R9: A break that begins inside a character first yields that character with its error flags. If the line stays low for the following character time, a second, all-zero character with `rx_brk` = 1 follows.
- R10: After a break character, no start bit is searched for until the line has been high for 8 consecutive oversample ticks. Lows after a shorter high period produce no character. Reception then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_data_bits | input | 2 | Data-bit count minus 5 |
| cfg_parity | input | 2 | Parity rule: 0 none, 1 even, 2 odd, 3 forced one |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break character indicator |

## Verification
A character strobe is due one clock after the oversample tick that lands on the centre of its last stop bit. Counted from the clock on which the start bit is driven, that is two synchronizer clocks, up to one tick of detection delay, eight ticks to the start centre and sixteen ticks per further bit. With the enable on every second clock, this puts the strobe at 32·k + 19 or 20 clocks, where k is the index of the last stop bit. The bench stamps every strobe with the clock count at a falling edge and accepts it only inside a ±8-clock window around that point. Glitch, idle-guard and break checks count the strobes over a whole interval and compare the totals with the expected number.

// File: rtl/uart_brk_rx_pkg.sv
// Shared types for the break-aware serial receiver.
// Assumes: parity codes are fixed by the top-level port encoding.
package uart_brk_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_BRKW
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_ONE  = 2'd3
    } par_mode_t;

    // Expected parity-bit level given the XOR of the received data bits.
    function automatic logic par_expected(input par_mode_t mode, input logic data_xor);
        case (mode)
            PAR_EVEN: par_expected = data_xor;
            PAR_ODD:  par_expected = ~data_xor;
            PAR_ONE:  par_expected = 1'b1;
            default:  par_expected = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_brk_rx_sync.sv
// Synchronizer bringing the asynchronous serial line into the clock domain.
// Assumes: the line idles high, so every stage resets to 1.
module uart_brk_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture of the line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= din;
            end
        end else begin : g_multi
            // Shift the line value through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_brk_rx_guard.sv
// Idle guard used after a break: counts consecutive high oversample ticks
// and signals release once half a bit time of high level has been seen.
// Assumes: 'armed' stays high for the whole wait, and the count restarts
// whenever it drops.
module uart_brk_rx_guard #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic line,
    output logic released
);

    localparam int              HALF   = OVS / 2;
    localparam int              CW     = $clog2(HALF + 1);
    localparam logic [CW-1:0]   HALF_C = CW'(HALF);

    logic [CW-1:0] hi_cnt;

    // Count consecutive high ticks; a low tick restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            hi_cnt <= '0;
        end else if (tick) begin
            if (!line)                hi_cnt <= '0;
            else if (hi_cnt != HALF_C) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign released = armed && (hi_cnt == HALF_C);

    // R10: release can only follow a tick on which the line was high.
    assert_release_after_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(line) && $past(tick));

endmodule

// File: rtl/uart_brk_rx_frame.sv
// Character framer: confirms the start bit, samples data, parity and stop
// bits at mid-bit, and classifies each character as normal, errored or break.
// Assumes: 'rxd' is already synchronized; 'tick' runs at OVS per bit;
// configuration does not change while a character is being received.
module uart_brk_rx_frame
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_MAX = 8,
    parameter int OVS      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxd,
    input  logic [1:0]          cfg_data_bits,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    input  logic                guard_released,
    output logic                guard_armed,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_brk
);

    localparam int             CW        = $clog2(OVS);
    localparam int             BW        = $clog2(DATA_MAX);
    localparam logic [CW-1:0]  START_MID = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0]  BIT_END   = CW'(OVS - 1);
    localparam logic [BW-1:0]  LAST_BASE = BW'(DATA_MAX - 4);

    rx_state_t             state;
    logic [CW-1:0]         os_cnt;
    logic [BW-1:0]         bit_idx;
    logic [DATA_MAX-1:0]   shreg;
    logic                  all_low;
    logic                  data_xor;
    logic                  perr_r;
    logic                  ferr_r;

    logic [BW-1:0]         last_idx;
    logic                  mid_bit;
    logic                  deliver;
    logic                  brk_now;
    logic                  fe_now;
    par_mode_t             pmode;

    // Decode configuration and the current sampling point.
    always_comb begin
        pmode    = par_mode_t'(cfg_parity);
        last_idx = LAST_BASE + BW'(cfg_data_bits);
        mid_bit  = tick && (os_cnt == BIT_END);
        deliver  = mid_bit && ((state == ST_STOP && !cfg_two_stop) || state == ST_STOP2);
        brk_now  = all_low && !rxd;
        fe_now   = (state == ST_STOP) ? !rxd : ferr_r;
    end

    assign guard_armed = (state == ST_BRKW);

    // Receive state machine and character assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            all_low  <= 1'b0;
            data_xor <= 1'b0;
            perr_r   <= 1'b0;
            ferr_r   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_brk   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !rxd) begin
                        state    <= ST_START;
                        os_cnt   <= '0;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        all_low  <= 1'b1;
                        data_xor <= 1'b0;
                        perr_r   <= 1'b0;
                        ferr_r   <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (os_cnt == START_MID) begin
                            os_cnt <= '0;
                            state  <= rxd ? ST_IDLE : ST_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                ST_BRKW: begin
                    if (guard_released) state <= ST_IDLE;
                end
                default: begin
                    if (tick) os_cnt <= mid_bit ? '0 : os_cnt + 1'b1;
                    if (mid_bit) begin
                        all_low <= all_low && !rxd;
                        case (state)
                            ST_DATA: begin
                                shreg[bit_idx] <= rxd;
                                data_xor       <= data_xor ^ rxd;
                                if (bit_idx == last_idx)
                                    state <= (pmode == PAR_NONE) ? ST_STOP : ST_PAR;
                                else
                                    bit_idx <= bit_idx + 1'b1;
                            end
                            ST_PAR: begin
                                perr_r <= (rxd != par_expected(pmode, data_xor));
                                state  <= ST_STOP;
                            end
                            ST_STOP: begin
                                ferr_r <= !rxd;
                                if (cfg_two_stop) state <= ST_STOP2;
                            end
                            default: ;
                        endcase
                    end
                end
            endcase

            // Hand the finished character out and pick the follow-on state.
            if (deliver) begin
                rx_valid <= 1'b1;
                rx_brk   <= brk_now;
                rx_data  <= brk_now ? '0 : shreg;
                rx_perr  <= !brk_now && perr_r;
                rx_ferr  <= !brk_now && fe_now;
                state    <= brk_now ? ST_BRKW : ST_IDLE;
            end
        end
    end

    // R3: the character strobe is a single-cycle pulse.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: outputs hold between strobes.
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data) && $stable(rx_brk));

    // R8: a break character carries zero data and no error flags.
    assert_break_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_brk |-> rx_data == '0 && !rx_perr && !rx_ferr);

    // R5: no parity error when parity is disabled.
    assert_no_perr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && cfg_parity == 2'd0 |-> !rx_perr);

    // R4: data phase is entered only if the line was low at the start mid-point.
    assert_start_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA && $past(state) == ST_START |-> !$past(rxd));

    // R10: leaving the post-break wait requires the idle guard's release.
    assert_break_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && $past(state) == ST_BRKW |-> $past(guard_released));

    // R2: bits above the configured character length are zero.
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_data & ~({DATA_MAX{1'b1}} >> (2'd3 - cfg_data_bits))) == '0);

endmodule

// File: rtl/uart_brk_rx.sv
// Top of the break-aware serial receiver: line synchronizer, character
// framer and post-break idle guard.
// Assumes: os_tick pulses OVS times per bit period; configuration is static.
module uart_brk_rx #(
    parameter int DATA_MAX    = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic [1:0]          cfg_data_bits,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_brk
);

    logic line_s;
    logic guard_armed;
    logic guard_released;

    uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_brk_rx_frame #(.DATA_MAX(DATA_MAX), .OVS(OVS)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (os_tick),
        .rxd           (line_s),
        .cfg_data_bits (cfg_data_bits),
        .cfg_parity    (cfg_parity),
        .cfg_two_stop  (cfg_two_stop),
        .guard_released(guard_released),
        .guard_armed   (guard_armed),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_perr       (rx_perr),
        .rx_ferr       (rx_ferr),
        .rx_brk        (rx_brk)
    );

    uart_brk_rx_guard #(.OVS(OVS)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .armed   (guard_armed),
        .line    (line_s),
        .released(guard_released)
    );

endmodule

// File: tb/uart_brk_rx_bench.sv
// Directed bench: a bit-level line model drives rxd; one task per scenario.
module uart_brk_rx_bench;

    localparam int BIT = 32;   // clocks per bit: os_tick every 2nd clock, 16 ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_data_bits = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int cap_n   = 0;
    logic [7:0] cap_d [64];
    logic       cap_pe[64];
    logic       cap_fe[64];
    logic       cap_bk[64];
    int         cap_c [64];
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        os_tick <= ~os_tick;
        cyc     <= cyc + 1;
    end

    // Record every strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (cap_n < 64) begin
                cap_d[cap_n]  = rx_data;
                cap_pe[cap_n] = rx_perr;
                cap_fe[cap_n] = rx_ferr;
                cap_bk[cap_n] = rx_brk;
                cap_c[cap_n]  = cyc;
            end
            cap_n = cap_n + 1;
        end
    end

    uart_brk_rx u_uart_brk_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int nclk);
        rxd = lvl;
        repeat (nclk) @(negedge clk);
    endtask

    // Bit-level frame model; returns cycle of start and index of last stop bit.
    task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit flip_par, input logic stop1,
                              input bit two, input logic stop2,
                              output int t0, output int k);
        logic p;
        logic [7:0] m;
        m = d & 8'((1 << nb) - 1);
        case (pm)
            1: p = ^m;
            2: p = ~^m;
            default: p = 1'b1;
        endcase
        t0 = cyc;
        drive(1'b0, BIT);
        for (int i = 0; i < nb; i++) drive(d[i], BIT);
        if (pm != 0) drive(p ^ flip_par, BIT);
        drive(stop1, BIT);
        if (two) drive(stop2, BIT);
        k = 1 + nb + ((pm != 0) ? 1 : 0) + (two ? 1 : 0);
        drive(1'b1, 2 * BIT);
    endtask

    task automatic expect_char(input int idx, input logic [7:0] d, input bit pe,
                               input bit fe, input bit bk, input string req);
        check(cap_d[idx] == d,   req, "data",  int'(cap_d[idx]), int'(d));
        check(cap_pe[idx] == pe, req, "perr",  int'(cap_pe[idx]), int'(pe));
        check(cap_fe[idx] == fe, req, "ferr",  int'(cap_fe[idx]), int'(fe));
        check(cap_bk[idx] == bk, req, "brk",   int'(cap_bk[idx]), int'(bk));
    endtask

    // One frame, one expected character, strobe inside its timing window.
    task automatic frame_case(input logic [7:0] d, input int nb, input int pm,
                              input bit flip, input logic s1, input bit two,
                              input logic s2, input logic [7:0] exp_d,
                              input bit pe, input bit fe, input string req);
        int base, t0, k, lo, hi;
        base = cap_n;
        send_frame(d, nb, pm, flip, s1, two, s2, t0, k);
        check(cap_n - base == 1, req, "strobe count", cap_n - base, 1);
        if (cap_n - base == 1) begin
            expect_char(base, exp_d, pe, fe, 1'b0, req);
            lo = t0 + BIT * k + 12;
            hi = t0 + BIT * k + 28;
            check(cap_c[base] >= lo && cap_c[base] <= hi, "R3", "strobe cycle",
                  cap_c[base] - t0, BIT * k + 20);
        end
    endtask

    task automatic t_reset();
        // R1: reset state of all outputs.
        check(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
        check(rx_data == 8'h00 && !rx_perr && !rx_ferr && !rx_brk, "R1", "outputs",
              int'({rx_perr, rx_ferr, rx_brk, rx_data}), 0);
    endtask

    task automatic t_normal();
        // R2 R3: 8 data bits, no parity, LSB first.
        cfg_data_bits = 2'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
        frame_case(8'hA5, 8, 0, 0, 1'b1, 0, 1'b1, 8'hA5, 0, 0, "R2");
        frame_case(8'h3C, 8, 0, 0, 1'b1, 0, 1'b1, 8'h3C, 0, 0, "R2");
    endtask

    task automatic t_short();
        // R2: 5-bit characters, upper bits read as zero.
        cfg_data_bits = 2'd0;
        frame_case(8'hF5, 5, 0, 0, 1'b1, 0, 1'b1, 8'h15, 0, 0, "R2");
        cfg_data_bits = 2'd2;
        frame_case(8'h4B, 7, 0, 0, 1'b1, 0, 1'b1, 8'h4B, 0, 0, "R2");
        cfg_data_bits = 2'd3;
    endtask

    task automatic t_parity();
        // R5: even, odd and forced-one rules, matching and mismatching.
        cfg_parity = 2'd1;
        frame_case(8'h5B, 8, 1, 0, 1'b1, 0, 1'b1, 8'h5B, 0, 0, "R5");
        frame_case(8'h5B, 8, 1, 1, 1'b1, 0, 1'b1, 8'h5B, 1, 0, "R5");
        cfg_parity = 2'd2;
        frame_case(8'h81, 8, 2, 0, 1'b1, 0, 1'b1, 8'h81, 0, 0, "R5");
        frame_case(8'h81, 8, 2, 1, 1'b1, 0, 1'b1, 8'h81, 1, 0, "R5");
        cfg_parity = 2'd3;
        frame_case(8'h00, 8, 3, 0, 1'b1, 0, 1'b1, 8'h00, 0, 0, "R5");
        frame_case(8'h00, 8, 3, 1, 1'b1, 0, 1'b1, 8'h00, 1, 0, "R5");
        cfg_parity = 2'd0;
    endtask

    task automatic t_glitch();
        // R4: a low shorter than half a bit yields no character.
        int base;
        base = cap_n;
        drive(1'b0, 8);
        drive(1'b1, 3 * BIT);
        check(cap_n == base, "R4", "glitch strobes", cap_n - base, 0);
    endtask

    task automatic t_framing();
        // R6: low first stop bit flags a framing error, data kept.
        frame_case(8'hC3, 8, 0, 0, 1'b0, 0, 1'b1, 8'hC3, 0, 1, "R6");
    endtask

    task automatic t_two_stop();
        // R7: second stop bit is sampled but never flags framing.
        cfg_two_stop = 1'b1;
        frame_case(8'h6C, 8, 0, 0, 1'b1, 1, 1'b0, 8'h6C, 0, 0, "R7");
        frame_case(8'h6C, 8, 0, 0, 1'b0, 1, 1'b1, 8'h6C, 0, 1, "R7");
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_break_boundary();
        // R8: line low for a whole character gives one zero break character.
        int base;
        base = cap_n;
        drive(1'b0, 11 * BIT);
        drive(1'b1, 3 * BIT);
        check(cap_n - base == 1, "R8", "break strobes", cap_n - base, 1);
        if (cap_n - base == 1) expect_char(base, 8'h00, 0, 0, 1, "R8");
        frame_case(8'h42, 8, 0, 0, 1'b1, 0, 1'b1, 8'h42, 0, 0, "R10");
    endtask

    task automatic t_break_guard();
        // R10: a short high after a break does not re-open start search.
        int base;
        base = cap_n;
        drive(1'b0, 12 * BIT);
        drive(1'b1, 6);
        drive(1'b0, 2 * BIT);
        drive(1'b1, 4 * BIT);
        check(cap_n - base == 1, "R10", "strobes after short high", cap_n - base, 1);
        if (cap_n - base == 1) expect_char(base, 8'h00, 0, 0, 1, "R10");
        frame_case(8'h99, 8, 0, 0, 1'b1, 0, 1'b1, 8'h99, 0, 0, "R10");
    endtask

    task automatic t_break_mid();
        // R9: damaged character first, then a zero break character.
        int base;
        base = cap_n;
        drive(1'b0, BIT);
        drive(1'b1, 3 * BIT);
        drive(1'b0, 24 * BIT);
        drive(1'b1, 3 * BIT);
        check(cap_n - base == 2, "R9", "strobes", cap_n - base, 2);
        if (cap_n - base == 2) begin
            expect_char(base, 8'h07, 0, 1, 0, "R9");
            expect_char(base + 1, 8'h00, 0, 0, 1, "R9");
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        t_reset();
        t_normal();
        t_short();
        t_parity();
        t_glitch();
        t_framing();
        t_two_stop();
        t_break_boundary();
        t_break_guard();
        t_break_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule